// File: doc/BRIEF.md
# Gated Event Counter with Edge-Sensed Interrupt

This block counts external events in a pair of cascaded counters, a low half and a high half. Both halves are clocked by one shared gate, so both run or both stop. A mode bit picks where the gate comes from: either an external gate pin or an internal periodic PWM waveform generated elsewhere on the chip. Software can therefore let the count run only inside windows that an outside signal or a timer waveform defines.

The selected gate signal is also an interrupt source. An edge detector watches it for a programmable edge: falling, rising or both. When that edge occurs, a sticky request flag is set. The interrupt line to the CPU is raised while the flag is set and the enable bit is on. The interrupt's vector number is provided as a constant output.

Software reaches the block through a small register port. Writes are single cycle and reads are combinational. The external gate pin and the event input are synchronized before use. The PWM input is assumed to be synchronous by default.

Top module: `gated_event_counter`

## Requirements
- R1: Control register (address 0) holds gate select at bit 0 (0 = external pin, 1 = PWM input), edge select at bits 2:1 and interrupt enable at bit 3. It reads back what was written, and every field is 0 after reset.
- R2: The counters advance only while the selected gate is high. While it is low, events leave both counters unchanged.
- R3: With gate select 0 only the external pin gates counting, and with gate select 1 only the PWM input gates counting. The unselected source has no effect.
- R4: The external pin and the event input pass through two synchronizing flip-flops. A count occurs on each rising edge of the synchronized event while the gate is high.
- R5: The low counter (address 2) and the high counter (address 3) are each 8 bits wide. When the low counter wraps from 0xFF to 0x00, the high counter increments.
- R6: Writing 1 to bit 1 of the flag register (address 1) clears both counters. That bit reads as 0.
- R7: Edge select encoding is 00 = falling, 01 = rising, 10 or 11 = both. Only the selected edge of the gate sets the request flag, which reads at bit 0 of address 1.
- R8: The request flag is sticky. It clears only when 0 is written to bit 0 of address 1, and writing 1 to that bit leaves it unchanged.
- R9: If a selected edge arrives in the same cycle as a flag-clear write, the flag stays set.
- R10: The interrupt output is high exactly while the request flag and the interrupt enable are both 1.
- R11: Changing gate select re-samples the newly selected source as the previous gate level, so the switch itself never sets the flag.
- R12: The vector output is the constant 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| evt_i | input | 1 | Asynchronous event input |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| pwm_i | input | 1 | Internal PWM gate waveform |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Constant interrupt vector number |

## Verification
On every cycle, the assertions check the following: the counters are frozen while the gate is low, the carry into the high half happens on the low half's wrap, a set flag survives any cycle without a clear write, a detected edge always leaves the flag set, and the interrupt stays low while masked. Some behaviours can only be shown by the bench's scenarios: which source the mode bit selects, the edge encoding, the absence of a spurious edge when the source is switched, and the synchronizer latency of the pin and event paths.

// File: rtl/evg_pkg.sv
package evg_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   // register addresses
   localparam logic [1:0] REG_CTRL   = 2'd0;
   localparam logic [1:0] REG_FLAG   = 2'd1;
   localparam logic [1:0] REG_CNT_LO = 2'd2;
   localparam logic [1:0] REG_CNT_HI = 2'd3;

   // control register fields
   localparam int CTRL_SEL_BIT  = 0;
   localparam int CTRL_EDGE_LSB = 1;
   localparam int CTRL_IEN_BIT  = 3;

   // flag register fields
   localparam int FLAG_REQ_BIT = 0;
   localparam int FLAG_CLR_BIT = 1;

endpackage

// File: rtl/evg_sync.sv
module evg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= d;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/evg_edge.sv
module evg_edge
   import evg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  edge_sel_e edge_sel,
   input  logic      reseed,
   input  logic      reseed_lvl,
   output logic      hit
);

   logic prev_q;
   logic rise_en, fall_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (reseed) prev_q <= reseed_lvl;
      else             prev_q <= lvl;
   end

   assign rise_en = (edge_sel != EDGE_FALL);
   assign fall_en = (edge_sel != EDGE_RISE);
   assign hit     = (rise_en & lvl & ~prev_q) | (fall_en & ~lvl & prev_q);

endmodule

// File: rtl/evg_cascade.sv
module evg_cascade #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] lo,
   output logic [CNT_W-1:0] hi
);

   logic carry;
   assign carry = inc & (&lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else if (clr) begin
         lo <= '0;
         hi <= '0;
      end else begin
         if (inc)   lo <= lo + 1'b1;
         if (carry) hi <= hi + 1'b1;
      end
   end

endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
   import evg_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PWM_SYNC    = 1'b0,
   parameter int VEC_W       = 8,
   parameter int VECTOR_ID   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              evt_i,
   input  logic              gate_pin_i,
   input  logic              pwm_i,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o
);

   localparam int CTRL_W = CTRL_IEN_BIT + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W too narrow for counter or control fields");
   end
   if (VECTOR_ID >= (1 << VEC_W)) begin : g_bad_vec
      $error("VECTOR_ID does not fit VEC_W");
   end

   logic              gate_sel_q;
   edge_sel_e         edge_q;
   logic              irq_en_q;
   logic              flag_q;
   logic              wr_ctrl, wr_flag;
   logic              ext_lvl, evt_s, pwm_lvl;
   logic              evt_prev_q, evt_pulse;
   logic              gate_lvl, next_lvl, reseed, edge_hit;
   logic [CNT_W-1:0]  cnt_lo, cnt_hi;
   logic              wdata_unused;

   assign wdata_unused = ^wdata;
   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign wr_flag = wr_en && (addr == REG_FLAG);

   // synchronizers for the pin-side inputs
   evg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({gate_pin_i, evt_i}),
      .q   ({ext_lvl, evt_s})
   );

   if (PWM_SYNC) begin : g_pwm_sync
      evg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pwm_sync (
         .clk (clk),
         .rst_n (rst_n),
         .d   (pwm_i),
         .q   (pwm_lvl)
      );
   end else begin : g_pwm_direct
      assign pwm_lvl = pwm_i;
   end

   // event rising-edge pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_prev_q <= 1'b0;
      else        evt_prev_q <= evt_s;
   end
   assign evt_pulse = evt_s & ~evt_prev_q;

   // gate selection; a source switch reseeds the edge history
   assign gate_lvl = gate_sel_q ? pwm_lvl : ext_lvl;
   assign next_lvl = wdata[CTRL_SEL_BIT] ? pwm_lvl : ext_lvl;
   assign reseed   = wr_ctrl && (wdata[CTRL_SEL_BIT] != gate_sel_q);

   evg_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (gate_lvl),
      .edge_sel   (edge_q),
      .reseed     (reseed),
      .reseed_lvl (next_lvl),
      .hit        (edge_hit)
   );

   evg_cascade #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_flag & wdata[FLAG_CLR_BIT]),
      .inc   (evt_pulse & gate_lvl),
      .lo    (cnt_lo),
      .hi    (cnt_hi)
   );

   // control and flag registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_sel_q <= 1'b0;
         edge_q     <= EDGE_FALL;
         irq_en_q   <= 1'b0;
      end else if (wr_ctrl) begin
         gate_sel_q <= wdata[CTRL_SEL_BIT];
         edge_q     <= edge_sel_e'(wdata[CTRL_EDGE_LSB +: 2]);
         irq_en_q   <= wdata[CTRL_IEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               flag_q <= 1'b0;
      else if (edge_hit)                        flag_q <= 1'b1;
      else if (wr_flag && !wdata[FLAG_REQ_BIT]) flag_q <= 1'b0;
   end

   assign irq_o = flag_q & irq_en_q;
   assign vec_o = VEC_W'(VECTOR_ID);

   always_comb begin
      unique case (addr)
         REG_CTRL:   rdata = DATA_W'({irq_en_q, edge_q, gate_sel_q});
         REG_FLAG:   rdata = DATA_W'(flag_q);
         REG_CNT_LO: rdata = DATA_W'(cnt_lo);
         default:    rdata = DATA_W'(cnt_hi);
      endcase
   end

endmodule

// File: rtl/gated_event_counter_chk.sv
module gated_event_counter_chk #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic              gate_lvl,
   input logic              evt_pulse,
   input logic              edge_hit,
   input logic              flag_q,
   input logic              irq_en_q,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt_lo,
   input logic [CNT_W-1:0]  cnt_hi
);

   logic cnt_clr_wr, flag_clr_wr;
   assign cnt_clr_wr  = wr_en && (addr == 2'd1) && wdata[1];
   assign flag_clr_wr = wr_en && (addr == 2'd1) && !wdata[0];

   a_r2_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_lvl && !cnt_clr_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lvl && evt_pulse && (&cnt_lo) && !cnt_clr_wr)
      |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + 1'b1));

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_wr) |=> flag_q);

   a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q);

   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_q || !flag_q) |-> !irq_o);

endmodule

bind gated_event_counter gated_event_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .gate_lvl  (gate_lvl),
   .evt_pulse (evt_pulse),
   .edge_hit  (edge_hit),
   .flag_q    (flag_q),
   .irq_en_q  (irq_en_q),
   .irq_o     (irq_o),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi)
);

// File: tb/gated_event_counter_tb.sv
module gated_event_counter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       evt_i = 1'b0;
   logic       gate_pin_i = 1'b0;
   logic       pwm_i = 1'b0;
   logic       irq_o;
   logic [7:0] vec_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gated_event_counter u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wdata (wdata), .rdata (rdata), .evt_i (evt_i),
      .gate_pin_i (gate_pin_i), .pwm_i (pwm_i), .irq_o (irq_o), .vec_o (vec_o)
   );

   // {sel, ext, pwm, n_events[7:0], expected_lo[7:0]}
   localparam logic [18:0] TBL [6] = '{
      {1'b0, 1'b1, 1'b0, 8'd3, 8'd3},
      {1'b0, 1'b0, 1'b1, 8'd4, 8'd0},
      {1'b1, 1'b0, 1'b1, 8'd5, 8'd5},
      {1'b1, 1'b1, 1'b0, 8'd2, 8'd0},
      {1'b0, 1'b1, 1'b1, 8'd6, 8'd6},
      {1'b1, 1'b0, 1'b0, 8'd7, 8'd0}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_events(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); evt_i = 1'b1;
         repeat (3) @(negedge clk);
         evt_i = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      #400000;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd, rd2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R12 / R10 reset state
      reg_read(2'd0, rd);  check("R1 ctrl reset", 16'(rd), 16'h0);
      reg_read(2'd1, rd);  check("R8 flag reset", 16'(rd), 16'h0);
      reg_read(2'd2, rd);  reg_read(2'd3, rd2);
      check("R5 counters reset", {rd2, rd}, 16'h0);
      check("R10 irq reset", 16'(irq_o), 16'h0);
      check("R12 vector", 16'(vec_o), 16'd6);

      // R2 R3 R4 table of gating vectors
      for (int k = 0; k < 6; k++) begin
         reg_write(2'd0, {7'd0, TBL[k][18]});
         gate_pin_i = TBL[k][17];
         pwm_i      = TBL[k][16];
         settle();
         reg_write(2'd1, 8'h02);
         pulse_events(int'(TBL[k][15:8]));
         reg_read(2'd2, rd); reg_read(2'd3, rd2);
         check("R2 R3 R4 gated count", {rd2, rd}, {8'd0, TBL[k][7:0]});
      end

      // R1 readback
      reg_write(2'd0, 8'h0D);
      reg_read(2'd0, rd); check("R1 ctrl readback", 16'(rd), 16'h0D);

      // R5 cascade
      reg_write(2'd0, 8'h00); gate_pin_i = 1'b1; settle();
      reg_write(2'd1, 8'h02);
      pulse_events(256);
      reg_read(2'd2, rd); reg_read(2'd3, rd2);
      check("R5 wrap to high", {rd2, rd}, 16'h0100);
      pulse_events(1);
      reg_read(2'd2, rd); reg_read(2'd3, rd2);
      check("R5 after wrap", {rd2, rd}, 16'h0101);

      // R6 counter clear, bit reads zero
      reg_write(2'd1, 8'h03);
      reg_read(2'd2, rd); reg_read(2'd3, rd2);
      check("R6 clear both", {rd2, rd}, 16'h0);
      reg_read(2'd1, rd); check("R6 clear bit reads 0", 16'(rd & 8'h02), 16'h0);

      // R7 edge encodings on PWM gate
      pwm_i = 1'b0;
      reg_write(2'd0, 8'h03);           // pwm, rising
      settle(); reg_write(2'd1, 8'h00);
      pwm_i = 1'b1; settle();
      reg_read(2'd1, rd); check("R7 rising sets", 16'(rd), 16'h1);
      reg_write(2'd1, 8'h00);
      pwm_i = 1'b0; settle();
      reg_read(2'd1, rd); check("R7 falling ignored in rise mode", 16'(rd), 16'h0);
      reg_write(2'd0, 8'h01);           // pwm, falling
      pwm_i = 1'b1; settle();
      reg_read(2'd1, rd); check("R7 rising ignored in fall mode", 16'(rd), 16'h0);
      pwm_i = 1'b0; settle();
      reg_read(2'd1, rd); check("R7 falling sets", 16'(rd), 16'h1);
      reg_write(2'd0, 8'h05);           // pwm, both
      reg_write(2'd1, 8'h00);
      pwm_i = 1'b1; settle();
      reg_read(2'd1, rd); check("R7 both: rise", 16'(rd), 16'h1);
      reg_write(2'd1, 8'h00);
      pwm_i = 1'b0; settle();
      reg_read(2'd1, rd); check("R7 both: fall", 16'(rd), 16'h1);

      // R10 interrupt masking
      check("R10 irq masked", 16'(irq_o), 16'h0);
      reg_write(2'd0, 8'h0D);
      #1 check("R10 irq enabled", 16'(irq_o), 16'h1);

      // R8 sticky: writing 1 keeps, writing 0 clears
      reg_write(2'd1, 8'h01);
      reg_read(2'd1, rd); check("R8 write 1 keeps flag", 16'(rd), 16'h1);
      reg_write(2'd1, 8'h00);
      reg_read(2'd1, rd); check("R8 write 0 clears", 16'(rd), 16'h0);
      reg_write(2'd1, 8'h01);
      reg_read(2'd1, rd); check("R8 write 1 does not set", 16'(rd), 16'h0);

      // R9 edge wins over simultaneous clear
      reg_write(2'd0, 8'h03);           // pwm, rising
      pwm_i = 1'b1; settle();
      pwm_i = 1'b0; settle();
      @(negedge clk);
      pwm_i = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      reg_read(2'd1, rd); check("R9 edge beats clear", 16'(rd), 16'h1);

      // R11 switching source creates no edge
      pwm_i = 1'b0; gate_pin_i = 1'b1;
      reg_write(2'd0, 8'h04);           // ext, both
      settle(); reg_write(2'd1, 8'h00);
      reg_write(2'd0, 8'h05);           // to pwm (level 0)
      settle();
      reg_read(2'd1, rd); check("R11 switch to pwm", 16'(rd), 16'h0);
      reg_write(2'd0, 8'h04);           // back to ext (level 1)
      settle();
      reg_read(2'd1, rd); check("R11 switch to pin", 16'(rd), 16'h0);

      // R4 external pin edge through synchronizer
      reg_write(2'd0, 8'h02);           // ext, rising
      gate_pin_i = 1'b0; settle();
      reg_write(2'd1, 8'h00);
      @(negedge clk); gate_pin_i = 1'b1;
      @(negedge clk);
      reg_read(2'd1, rd); check("R4 pin not yet through sync", 16'(rd), 16'h0);
      settle();
      reg_read(2'd1, rd); check("R4 pin edge sets flag", 16'(rd), 16'h1);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule